// File: doc/BRIEF.md
# Prefix-OR Leading-Zero Counter

This block measures how many zero bits precede the first one in an input word, counting from the most significant end. It sits in front of the left shift that normalizes the result of a floating-point add or subtract. Two views of the same answer leave the block. The first is a thermometer mask: each output position is the OR of that input bit and every bit above it. The second is the zero count as a binary number that is one bit wider than log2 of the width, so an all-zero word can report the full width.

The mask comes from a parallel prefix OR network with logarithmic depth and a gate count linear in the width. The binary count comes from a separate recursive tree. At each level the tree counts the upper and lower halves. The most significant bit of the upper half's count shows that the upper half is all zero, and that bit picks the lower count plus half the width. When the upper half holds a one, the tree keeps the upper count. The adder is a half-adder on the top bit of the lower count. A parameter adds an output register with one cycle of latency.

Top module: `lzc_norm`

## Requirements
- R1: Bit j of `mask_o` is the OR of `vec_i[WIDTH-1:j]`, where `vec_i[WIDTH-1]` is the most significant bit.
- R2: `cnt_o` equals the number of consecutive zero bits of `vec_i`, counting down from bit WIDTH-1.
- R3: `cnt_o` equals the number of zero bits in `mask_o`.
- R4: An all-zero input gives `cnt_o` equal to WIDTH and an all-zero mask.
- R5: An all-one input gives `cnt_o` of 0 and an all-one mask.
- R6: The mask is a thermometer: if bit j+1 of `mask_o` is 1, then bit j is also 1.
- R7: An input with a single one at bit p gives ones in `mask_o[p:0]`, zeros above, and `cnt_o` = WIDTH-1-p. For example, at width 4, input 0010 gives mask 0011 and count 010.
- R8: With REG_OUT=1, the outputs show the result for the input present at the previous rising clock edge. While `rst_n` is low, both outputs are 0.
- R9: The upper-half flag is set exactly when `vec_i[WIDTH-1:WIDTH/2]` is zero. When it is set, `cnt_o` equals WIDTH/2 plus the leading-zero count of the lower half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| vec_i | input | WIDTH | Word to examine; bit WIDTH-1 is the most significant |
| mask_o | output | WIDTH | Prefix-OR thermometer mask |
| cnt_o | output | log2(WIDTH)+1 | Leading-zero count, 0 to WIDTH |

## Verification
The mask and the count come from two separate networks and are produced in the same cycle for the same word, so every result lets the bench judge whether the two agree. Each scoreboard item checks the mask and the count against the bench's own scan of the word. It also checks that the count equals the zero positions of the delivered mask. Words with an empty upper half drive the half-select and the lower-half add. Single-one, all-zero and all-one words test the ends of the count range.

// File: rtl/lzc_pkg.sv
package lzc_pkg;
  // Width of a leading-zero count for a word of the given size.
  function automatic int count_width(input int width);
    return $clog2(width) + 1;
  endfunction
endpackage

// File: rtl/pfx_or_net.sv
// Prefix OR, r[0] is highest priority: p[i] = |r[0..i].
// Recursive pair-combine / fill-in structure: linear gates, log depth.
module pfx_or_net #(
  parameter int N = 32
) (
  input  logic [N-1:0] r,
  output logic [N-1:0] p
);
  generate
    if (N == 1) begin : g_leaf
      assign p = r;
    end else begin : g_node
      localparam int H = N / 2;
      logic [H-1:0] pair_or;
      logic [H-1:0] pair_pfx;
      for (genvar j = 0; j < H; j++) begin : g_pair
        assign pair_or[j] = r[2*j] | r[2*j+1];
      end
      pfx_or_net #(.N(H)) u_sub (.r(pair_or), .p(pair_pfx));
      for (genvar j = 0; j < H; j++) begin : g_fill
        assign p[2*j+1] = pair_pfx[j];
        if (j == 0) begin : g_first
          assign p[0] = r[0];
        end else begin : g_rest
          assign p[2*j] = pair_pfx[j-1] | r[2*j];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/lz_merge.sv
// Combines the counts of two halves. The top bit of the upper count
// signals an empty upper half; then the result is H + lower count,
// formed with a half adder on the lower count's top bit.
module lz_merge #(
  parameter int KH = 2
) (
  input  logic [KH-1:0] cnt_up,
  input  logic [KH-1:0] cnt_lo,
  output logic [KH:0]   cnt
);
  function automatic logic [KH:0] merge(input logic [KH-1:0] up,
                                        input logic [KH-1:0] lo);
    if (up[KH-1])
      return {lo[KH-1], ~lo[KH-1], lo[KH-2:0]};
    else
      return {1'b0, up};
  endfunction

  assign cnt = merge(cnt_up, cnt_lo);
endmodule

// File: rtl/lz_tree.sv
// Recursive leading-zero counter; x[N-1] is the most significant bit.
module lz_tree #(
  parameter int N = 16,
  localparam int CW = $clog2(N) + 1
) (
  input  logic [N-1:0]  x,
  output logic [CW-1:0] cnt
);
  generate
    if (N == 2) begin : g_base
      assign cnt = {~x[1] & ~x[0], ~x[1] & x[0]};
    end else begin : g_split
      localparam int H  = N / 2;
      localparam int KH = $clog2(H) + 1;
      logic [KH-1:0] c_up;
      logic [KH-1:0] c_lo;
      lz_tree  #(.N(H))   u_up (.x(x[N-1:H]), .cnt(c_up));
      lz_tree  #(.N(H))   u_lo (.x(x[H-1:0]), .cnt(c_lo));
      lz_merge #(.KH(KH)) u_mg (.cnt_up(c_up), .cnt_lo(c_lo), .cnt(cnt));
    end
  endgenerate
endmodule

// File: rtl/lzc_norm.sv
// Leading-zero counter with prefix-OR mask. WIDTH is a power of two, >= 4.
module lzc_norm
  import lzc_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int CW = count_width(WIDTH),
  localparam int H  = WIDTH / 2,
  localparam int KH = count_width(H)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] vec_i,
  output logic [WIDTH-1:0] mask_o,
  output logic [CW-1:0]    cnt_o
);
  // ---------------- prefix-OR mask ----------------
  logic [WIDTH-1:0] rev_vec;
  logic [WIDTH-1:0] rev_pfx;
  logic [WIDTH-1:0] mask_c;

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign rev_vec[i]          = vec_i[WIDTH-1-i];
    assign mask_c[WIDTH-1-i]   = rev_pfx[i];
  end

  pfx_or_net #(.N(WIDTH)) u_pfx (.r(rev_vec), .p(rev_pfx));

  // ---------------- binary count ----------------
  logic [KH-1:0] cnt_up;
  logic [KH-1:0] cnt_lo;
  logic [CW-1:0] cnt_c;
  logic          upper_zero;   // named event: upper half empty

  lz_tree  #(.N(H))   u_up (.x(vec_i[WIDTH-1:H]), .cnt(cnt_up));
  lz_tree  #(.N(H))   u_lo (.x(vec_i[H-1:0]),     .cnt(cnt_lo));
  lz_merge #(.KH(KH)) u_mg (.cnt_up(cnt_up), .cnt_lo(cnt_lo), .cnt(cnt_c));

  assign upper_zero = cnt_up[KH-1];

  // ---------------- optional output register ----------------
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mask_o <= '0;
          cnt_o  <= '0;
        end else begin
          mask_o <= mask_c;
          cnt_o  <= cnt_c;
        end
      end

      a_r8_reg_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mask_o == $past(mask_c) && cnt_o == $past(cnt_c)))
        else $error("R8: output register does not follow previous result");
    end else begin : g_comb
      assign mask_o = mask_c;
      assign cnt_o  = cnt_c;
    end
  endgenerate

  // ---------------- assertions ----------------
  a_r1_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    mask_c[WIDTH-1] == vec_i[WIDTH-1])
    else $error("R1: mask top bit differs from input top bit");

  a_r3_mask_vs_count: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_c) == $countones(~mask_c))
    else $error("R3: count disagrees with mask zero positions");

  a_r4_all_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_i == '0) |-> (cnt_c == CW'(WIDTH) && mask_c == '0))
    else $error("R4: all-zero input not counted as WIDTH");

  a_r5_all_one: assert property (@(posedge clk) disable iff (!rst_n)
    (&vec_i) |-> (cnt_c == '0 && (&mask_c)))
    else $error("R5: all-one input gives nonzero count");

  for (genvar j = 0; j < WIDTH - 1; j++) begin : g_thermo
    a_r6_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
      mask_c[j+1] |-> mask_c[j])
      else $error("R6: mask is not a thermometer at bit %0d", j);
  end

  a_r9_half_flag: assert property (@(posedge clk) disable iff (!rst_n)
    upper_zero == (vec_i[WIDTH-1:H] == '0))
    else $error("R9: upper-half flag wrong");

  a_r9_half_select: assert property (@(posedge clk) disable iff (!rst_n)
    upper_zero |-> (cnt_c == CW'(H) + CW'(cnt_lo)))
    else $error("R9: empty upper half did not add half width");
endmodule

// File: tb/tb_lzc_norm.sv
module tb_lzc_norm;
  localparam int WIDTH = 32;
  localparam int CW    = $clog2(WIDTH) + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [WIDTH-1:0] vec_i = '0;
  logic [WIDTH-1:0] mask_o;
  logic [CW-1:0]    cnt_o;

  int total = 0;
  int bad   = 0;

  logic [WIDTH-1:0] q_mask[$];
  logic [CW-1:0]    q_cnt[$];
  string            q_tag[$];

  always #10 clk = ~clk;   // 50 MHz

  lzc_norm #(.WIDTH(WIDTH), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .vec_i(vec_i), .mask_o(mask_o), .cnt_o(cnt_o));

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Bench model: scan from the top bit, running OR for the mask.
  function automatic void model(input logic [WIDTH-1:0] v,
                                output logic [WIDTH-1:0] m,
                                output logic [CW-1:0] c);
    logic seen = 1'b0;
    int zeros = 0;
    for (int b = WIDTH - 1; b >= 0; b--) begin
      seen = seen | v[b];
      m[b] = seen;
      if (!seen) zeros++;
    end
    c = CW'(zeros);
  endfunction

  // Driver: apply on the falling edge, push the expectation.
  task automatic drive(input logic [WIDTH-1:0] v, input string tag);
    logic [WIDTH-1:0] m;
    logic [CW-1:0] c;
    @(negedge clk);
    vec_i = v;
    model(v, m, c);
    q_mask.push_back(m);
    q_cnt.push_back(c);
    q_tag.push_back(tag);
  endtask

  // Monitor: 5 ns after each rising edge the register holds the result
  // for the word applied at the preceding falling edge (R8).
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q_mask.size() > 0) begin
        logic [WIDTH-1:0] em;
        logic [CW-1:0] ec;
        string tg;
        int zeros_in_mask;
        em = q_mask.pop_front();
        ec = q_cnt.pop_front();
        tg = q_tag.pop_front();
        check({tg, " R1 mask"}, 64'(mask_o), 64'(em));
        check({tg, " R2 count"}, 64'(cnt_o), 64'(ec));
        zeros_in_mask = WIDTH - $countones(mask_o);
        check({tg, " R3 mask-vs-count"}, 64'(cnt_o), 64'(zeros_in_mask));
        check({tg, " R6 thermometer"},
              64'((mask_o & (mask_o + 1'b1)) == '0 || (mask_o == '0)), 64'(1));
      end
    end
  end

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Watchdog
  initial begin
    #(20 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    vec_i = '1;
    repeat (3) @(negedge clk);
    check("R8 reset mask", 64'(mask_o), 64'(0));
    check("R8 reset count", 64'(cnt_o), 64'(0));
    rst_n = 1'b1;

    drive('0, "R4 all-zero");
    drive('1, "R5 all-one");
    for (int p = 0; p < WIDTH; p++) drive(WIDTH'(1) << p, "R7 single-one");
    // upper half empty, varied lower half: half-select path
    for (int i = 0; i < 40; i++)
      drive({{(WIDTH/2){1'b0}}, (WIDTH/2)'($urandom) >> (i % 17)}, "R9 upper-empty");
    // random with varied leading-zero depth
    for (int i = 0; i < 200; i++)
      drive(WIDTH'($urandom) >> (i % (WIDTH + 1)), "R2 random");
    drive(WIDTH'(1) << (WIDTH/2), "R9 boundary");
    drive(WIDTH'(1) << (WIDTH/2 - 1), "R9 boundary");

    repeat (3) @(negedge clk);
    check("R8 queue drained", 64'(q_mask.size()), 64'(0));

    // R8: reset clears a nonzero registered result
    drive('1, "R5 pre-reset");
    @(posedge clk);
    #5;
    void'(q_mask.pop_front());
    void'(q_cnt.pop_front());
    void'(q_tag.pop_front());
    @(negedge clk);
    vec_i = '0;
    rst_n = 1'b0;
    #2;
    check("R8 async reset mask", 64'(mask_o), 64'(0));
    check("R8 async reset count", 64'(cnt_o), 64'(0));
    finish_run();
  end
endmodule